// File: doc/BRIEF.md
# CAN Fault-Confinement State Tracker

This block turns snapshots of a CAN controller's error-flag byte into the node's fault-confinement state: error-active, error-warning, error-passive or bus-off. Each time a snapshot is strobed in, a strict priority decode of the bus-off, passive and warning flags picks the new state. The block keeps saturating counts of how often the node went into warning and into passive, and of how many receive-buffer overflows were seen.

When the snapshot arrives with the error-interrupt bit set, the block also emits an event record. The record is a two-bit class plus a detail byte, and it comes with a one-cycle valid pulse. A host-side error reporter forwards it. Once bus-off is reached the tracker freezes. It leaves that state only when a restart request returns it to error-active.

Top module: `cerr_state_tracker`

## Requirements
- R1: After synchronous reset the state is error-active, all three counters are zero and `evt_valid` is low. State encoding: 0 active, 1 warning, 2 passive, 3 bus-off.
- R2: The flag byte is decoded as follows: bit1 receive warning, bit2 transmit warning, bit3 receive passive, bit4 transmit passive, bit5 bus-off, bit6 and bit7 receive-buffer overflows (bit0 is unused). The new state is bus-off if bit5 is set, else passive if bit4 or bit3 is set, else warning if bit2 or bit1 is set, else active. It is visible on the clock edge that accepts the strobe.
- R3: `warn_entries` increments when the previous state was active and the new state is warning, passive or bus-off.
- R4: `passive_entries` increments when the previous state was active or warning and the new state is passive or bus-off. A single jump from active to bus-off therefore increments both R3 and R4 counters.
- R5: On an accepted sample with the error-interrupt bit set, `overflow_count` rises by the number of set overflow bits (0, 1 or 2). Without the interrupt bit it is unchanged.
- R6: `evt_valid` pulses for one cycle after, and only after, an accepted sample that carries the error-interrupt bit.
- R7: Event class bit1 marks bus-off. Class bit0 marks a controller condition: warning, passive or any overflow. Detail bits: bit0 receive warning, bit1 transmit warning, bit2 receive passive, bit3 transmit passive, bit4 overflow. At most one of bits 3..0 is set, and it is the one chosen by the R2 priority. Bus-off sets none of them.
- R8: While the state is bus-off and no restart is requested, samples change neither the state nor the counters, and they emit no event.
- R9: A restart request sets the state to error-active on the next edge and keeps the counters. A sample strobed in the same cycle is dropped.
- R10: Every counter saturates at 2^CNT_W-1 and never wraps.
- R11: With the strobe low, the flag byte and the error-interrupt bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Snapshot strobe |
| smp_flags | input | 8 | Error-flag byte (layout in R2) |
| smp_err_irq | input | 1 | Error-interrupt bit accompanying the snapshot |
| restart_req | input | 1 | Return to error-active |
| fc_state | output | 2 | Fault-confinement state |
| warn_entries | output | CNT_W | Entries into warning or worse |
| passive_entries | output | CNT_W | Entries into passive or worse |
| overflow_count | output | CNT_W | Receive overflows seen |
| evt_valid | output | 1 | Event record valid pulse |
| evt_class | output | 2 | Event class bits |
| evt_detail | output | 8 | Event detail byte |

## Verification
Every result is registered once. State, counters and the event record are all due on the first rising edge after the strobe, and `evt_valid` falls one edge later. The bench drives inputs on falling edges. A behavioural model advances on the same rising edge, and all outputs are compared against it at the following falling edge. The directed checks sample at that same falling edge, so a design that is one edge early or late, or that holds a pulse for two cycles, miscompares.

// File: rtl/cerr_pkg.sv
package cerr_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARNING = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_RX_WARN = 3'd1,
        CAUSE_TX_WARN = 3'd2,
        CAUSE_RX_PASS = 3'd3,
        CAUSE_TX_PASS = 3'd4,
        CAUSE_BUSOFF  = 3'd5
    } fc_cause_e;

    // flag byte positions
    localparam int FLG_RX_WARN = 1;
    localparam int FLG_TX_WARN = 2;
    localparam int FLG_RX_PASS = 3;
    localparam int FLG_TX_PASS = 4;
    localparam int FLG_BUSOFF  = 5;
    localparam int FLG_OVF0    = 6;
    localparam int FLG_OVF1    = 7;

    // event detail positions
    localparam int DET_RX_WARN = 0;
    localparam int DET_TX_WARN = 1;
    localparam int DET_RX_PASS = 2;
    localparam int DET_TX_PASS = 3;
    localparam int DET_OVF     = 4;

    // event class positions
    localparam int CLS_CTRL   = 0;
    localparam int CLS_BUSOFF = 1;

    localparam int FLAG_W   = 8;
    localparam int DETAIL_W = 8;
    localparam int CLASS_W  = 2;

    typedef struct packed {
        fc_state_e state;
        fc_cause_e cause;
    } fc_decision_t;

    typedef struct packed {
        logic [CLASS_W-1:0]  cls;
        logic [DETAIL_W-1:0] detail;
    } fc_event_t;

    function automatic logic [1:0] ovf_bits(input logic [FLAG_W-1:0] f);
        return {1'b0, f[FLG_OVF0]} + {1'b0, f[FLG_OVF1]};
    endfunction

endpackage

// File: rtl/fc_priority_decode.sv
module fc_priority_decode
    import cerr_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    output fc_decision_t      decision
);
    always_comb begin
        if (flags[FLG_BUSOFF]) begin
            decision.state = FC_BUSOFF;
            decision.cause = CAUSE_BUSOFF;
        end else if (flags[FLG_TX_PASS]) begin
            decision.state = FC_PASSIVE;
            decision.cause = CAUSE_TX_PASS;
        end else if (flags[FLG_RX_PASS]) begin
            decision.state = FC_PASSIVE;
            decision.cause = CAUSE_RX_PASS;
        end else if (flags[FLG_TX_WARN]) begin
            decision.state = FC_WARNING;
            decision.cause = CAUSE_TX_WARN;
        end else if (flags[FLG_RX_WARN]) begin
            decision.state = FC_WARNING;
            decision.cause = CAUSE_RX_WARN;
        end else begin
            decision.state = FC_ACTIVE;
            decision.cause = CAUSE_NONE;
        end
    end
endmodule

// File: rtl/fc_event_builder.sv
module fc_event_builder
    import cerr_pkg::*;
(
    input  fc_decision_t decision,
    input  logic [1:0]   ovf_seen,
    output fc_event_t    record
);
    logic any_ovf;
    assign any_ovf = (ovf_seen != 2'd0);

    always_comb begin
        record = '0;
        unique case (decision.cause)
            CAUSE_RX_WARN: record.detail[DET_RX_WARN] = 1'b1;
            CAUSE_TX_WARN: record.detail[DET_TX_WARN] = 1'b1;
            CAUSE_RX_PASS: record.detail[DET_RX_PASS] = 1'b1;
            CAUSE_TX_PASS: record.detail[DET_TX_PASS] = 1'b1;
            default: ;
        endcase
        record.detail[DET_OVF] = any_ovf;
        record.cls[CLS_BUSOFF] = (decision.state == FC_BUSOFF);
        record.cls[CLS_CTRL]   = any_ovf ||
                                 (decision.state == FC_WARNING) ||
                                 (decision.state == FC_PASSIVE);
    end
endmodule

// File: rtl/fc_sat_counter.sv
module fc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   step,
    output logic [W-1:0] count
);
    localparam logic [W:0] LIMIT = {1'b0, {W{1'b1}}};

    logic [W:0] sum;
    assign sum = {1'b0, count} + {{(W-1){1'b0}}, step};

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (sum > LIMIT)
            count <= LIMIT[W-1:0];
        else
            count <= sum[W-1:0];
    end

    // R10: a full counter stays full
    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (count == LIMIT[W-1:0]) |=> (count == LIMIT[W-1:0]));

    // R10: never decreases outside reset
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (count >= $past(count)));
endmodule

// File: rtl/cerr_state_tracker.sv
module cerr_state_tracker
    import cerr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic [7:0]         smp_flags,
    input  logic               smp_err_irq,
    input  logic               restart_req,
    output logic [1:0]         fc_state,
    output logic [CNT_W-1:0]   warn_entries,
    output logic [CNT_W-1:0]   passive_entries,
    output logic [CNT_W-1:0]   overflow_count,
    output logic               evt_valid,
    output logic [1:0]         evt_class,
    output logic [7:0]         evt_detail
);
    fc_state_e    cur_q;
    fc_decision_t decision;
    fc_event_t    rec_d, rec_q;
    logic         accept;
    logic         emit;
    logic [1:0]   warn_step, pass_step, ovf_step;

    fc_priority_decode u_decode (
        .flags    (smp_flags),
        .decision (decision)
    );

    fc_event_builder u_event (
        .decision (decision),
        .ovf_seen (ovf_bits(smp_flags)),
        .record   (rec_d)
    );

    assign accept = smp_valid && !restart_req && (cur_q != FC_BUSOFF);
    assign emit   = accept && smp_err_irq;

    always_comb begin
        warn_step = 2'd0;
        pass_step = 2'd0;
        if (accept && cur_q == FC_ACTIVE && decision.state != FC_ACTIVE)
            warn_step = 2'd1;
        if (accept && (cur_q == FC_ACTIVE || cur_q == FC_WARNING) &&
            (decision.state == FC_PASSIVE || decision.state == FC_BUSOFF))
            pass_step = 2'd1;
        ovf_step = emit ? ovf_bits(smp_flags) : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= FC_ACTIVE;
        else if (restart_req)
            cur_q <= FC_ACTIVE;
        else if (accept)
            cur_q <= decision.state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid <= 1'b0;
            rec_q     <= '0;
        end else begin
            evt_valid <= emit;
            if (emit)
                rec_q <= rec_d;
        end
    end

    fc_sat_counter #(.W(CNT_W)) u_warn_cnt (
        .clk(clk), .rst(rst), .step(warn_step), .count(warn_entries));
    fc_sat_counter #(.W(CNT_W)) u_pass_cnt (
        .clk(clk), .rst(rst), .step(pass_step), .count(passive_entries));
    fc_sat_counter #(.W(CNT_W)) u_ovf_cnt (
        .clk(clk), .rst(rst), .step(ovf_step), .count(overflow_count));

    assign fc_state   = cur_q;
    assign evt_class  = rec_q.cls;
    assign evt_detail = rec_q.detail;

    // R8: bus-off holds without a restart
    assert_busoff_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (fc_state == FC_BUSOFF && !restart_req) |=> (fc_state == FC_BUSOFF));

    // R8: nothing counted or reported while frozen
    assert_busoff_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (fc_state == FC_BUSOFF && !restart_req) |=>
            ($stable(warn_entries) && $stable(passive_entries) &&
             $stable(overflow_count) && !evt_valid));

    // R9: restart lands in error-active
    assert_restart_active_R9: assert property (@(posedge clk) disable iff (rst)
        restart_req |=> (fc_state == FC_ACTIVE));

    // R6: an event needs a strobe with the interrupt bit
    assert_evt_source_R6: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(smp_valid && smp_err_irq && !restart_req));

    // R7: at most one warning/passive detail bit
    assert_single_cause_R7: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $onehot0(evt_detail[3:0]));

    // R11: no strobe, no change
    assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(smp_valid) && !$past(restart_req)) |->
            ($stable(fc_state) && $stable(warn_entries) &&
             $stable(overflow_count) && !evt_valid));
endmodule

// File: tb/tb_cerr_state_tracker.sv
`timescale 1ns/1ps
module tb_cerr_state_tracker;
    localparam int CNT_W = 16;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic [7:0]       smp_flags = 8'h00;
    logic             smp_err_irq = 1'b0;
    logic             restart_req = 1'b0;
    logic [1:0]       fc_state;
    logic [CNT_W-1:0] warn_entries, passive_entries, overflow_count;
    logic             evt_valid;
    logic [1:0]       evt_class;
    logic [7:0]       evt_detail;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cerr_state_tracker #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_flags(smp_flags),
        .smp_err_irq(smp_err_irq), .restart_req(restart_req),
        .fc_state(fc_state), .warn_entries(warn_entries),
        .passive_entries(passive_entries), .overflow_count(overflow_count),
        .evt_valid(evt_valid), .evt_class(evt_class), .evt_detail(evt_detail));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_state = 0, m_warn = 0, m_pass = 0, m_ovf = 0;
    int m_ev = 0, m_cls = 0, m_det = 0;

    always @(posedge clk) begin
        int ns, d, c, o;
        if (rst) begin
            m_state = 0; m_warn = 0; m_pass = 0; m_ovf = 0; m_ev = 0;
        end else begin
            m_ev = 0;
            if (restart_req) begin
                m_state = 0;
            end else if (smp_valid && m_state != 3) begin
                d = 0;
                if (smp_flags[5]) ns = 3;
                else if (smp_flags[4]) begin ns = 2; d = 8; end
                else if (smp_flags[3]) begin ns = 2; d = 4; end
                else if (smp_flags[2]) begin ns = 1; d = 2; end
                else if (smp_flags[1]) begin ns = 1; d = 1; end
                else ns = 0;
                if (m_state == 0 && ns >= 1) m_warn = (m_warn < MAXC) ? m_warn + 1 : MAXC;
                if (m_state <= 1 && ns >= 2) m_pass = (m_pass < MAXC) ? m_pass + 1 : MAXC;
                if (smp_err_irq) begin
                    o = int'(smp_flags[6]) + int'(smp_flags[7]);
                    m_ovf = (m_ovf + o > MAXC) ? MAXC : m_ovf + o;
                    c = 0;
                    if (ns == 3) c += 2;
                    if (ns == 1 || ns == 2 || o > 0) c += 1;
                    if (o > 0) d += 16;
                    m_ev = 1; m_cls = c; m_det = d;
                end
                m_state = ns;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 state vs model", fc_state, m_state);
            chk("R3 warn_entries vs model", warn_entries, m_warn);
            chk("R4 passive_entries vs model", passive_entries, m_pass);
            chk("R5 overflow_count vs model", overflow_count, m_ovf);
            chk("R6 evt_valid vs model", evt_valid, m_ev);
            if (m_ev == 1) begin
                chk("R7 evt_class vs model", evt_class, m_cls);
                chk("R7 evt_detail vs model", evt_detail, m_det);
            end
        end
    end

    task automatic apply(input logic [7:0] f, input logic irq, input logic rs);
        @(negedge clk);
        smp_valid = 1'b1; smp_flags = f; smp_err_irq = irq; restart_req = rs;
        @(negedge clk);
        smp_valid = 1'b0; smp_flags = 8'h00; smp_err_irq = 1'b0; restart_req = 1'b0;
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart_req = 1'b1;
        @(negedge clk);
        restart_req = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 state after reset", fc_state, 0);
        chk("R1 warn after reset", warn_entries, 0);
        chk("R1 overflow after reset", overflow_count, 0);
        chk("R1 evt_valid after reset", evt_valid, 0);

        // R11 inputs without strobe ignored
        smp_flags = 8'hFF; smp_err_irq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 no strobe state", fc_state, 0);
        chk("R11 no strobe evt", evt_valid, 0);
        chk("R11 no strobe overflow", overflow_count, 0);
        smp_flags = 8'h00; smp_err_irq = 1'b0;

        apply(8'h02, 1, 0);
        chk("R2 rx warn state", fc_state, 1);
        chk("R3 warn count", warn_entries, 1);
        chk("R6 evt pulse", evt_valid, 1);
        chk("R7 class ctrl", evt_class, 1);
        chk("R7 detail rx warn", evt_detail, 8'h01);
        @(negedge clk);
        chk("R6 pulse single cycle", evt_valid, 0);

        apply(8'h04, 1, 0);
        chk("R3 warning->warning no count", warn_entries, 1);
        chk("R7 detail tx warn", evt_detail, 8'h02);

        apply(8'h08, 0, 0);
        chk("R2 rx passive", fc_state, 2);
        chk("R4 passive from warning", passive_entries, 1);
        chk("R6 no irq no event", evt_valid, 0);

        apply(8'h00, 1, 0);
        chk("R2 back to active", fc_state, 0);
        chk("R7 active class", evt_class, 0);
        chk("R7 active detail", evt_detail, 0);

        apply(8'h18, 1, 0);
        chk("R7 tx passive priority", evt_detail, 8'h08);
        chk("R4 passive count", passive_entries, 2);

        apply(8'h00, 0, 0);
        apply(8'h20, 1, 0);
        chk("R2 bus-off", fc_state, 3);
        chk("R3 jump bumps warn", warn_entries, 3);
        chk("R4 jump bumps passive", passive_entries, 3);
        chk("R7 bus-off class", evt_class, 2);
        chk("R7 bus-off detail", evt_detail, 0);

        apply(8'hC0, 1, 0);
        chk("R8 frozen state", fc_state, 3);
        chk("R8 frozen overflow", overflow_count, 0);
        chk("R8 frozen no event", evt_valid, 0);

        apply(8'h02, 1, 1);
        chk("R9 restart active", fc_state, 0);
        chk("R9 concurrent sample dropped", warn_entries, 3);
        chk("R9 no event on restart", evt_valid, 0);

        apply(8'hC0, 1, 0);
        chk("R5 two overflows", overflow_count, 2);
        chk("R7 overflow detail", evt_detail, 8'h10);
        chk("R7 overflow class", evt_class, 1);
        apply(8'h40, 0, 0);
        chk("R5 overflow needs irq", overflow_count, 2);
        apply(8'h80, 1, 0);
        chk("R5 one overflow", overflow_count, 3);

        apply(8'h16, 1, 0);
        chk("R2 passive over warning", fc_state, 2);
        chk("R7 detail only tx passive", evt_detail, 8'h08);

        apply(8'hE0, 1, 0);
        chk("R4 passive->busoff no count", passive_entries, 4);
        chk("R7 busoff plus overflow class", evt_class, 3);
        chk("R5 overflow in busoff entry", overflow_count, 5);

        do_restart();
        chk("R9 restart alone", fc_state, 0);

        // R10 saturation
        @(negedge clk);
        smp_valid = 1'b1; smp_flags = 8'hC0; smp_err_irq = 1'b1;
        repeat (32770) @(negedge clk);
        smp_valid = 1'b0; smp_flags = 8'h00; smp_err_irq = 1'b0;
        @(negedge clk);
        chk("R10 overflow saturates", overflow_count, MAXC);

        done = 1;
        summary();
    end
endmodule